// File: doc/BRIEF.md
# Priority Interrupt Controller with Acknowledge

This block gathers interrupt sources for a single processor core and raises one request line toward it. The sources are a few external lines, a few timer event inputs and a few inter-processor doorbells. Each source carries a programmable priority and a programmable vector. External lines can each be set to edge or level sensing. Timer and doorbell sources are always edge-sensed.

The core reads the acknowledge strobe and receives the vector of the current winner one cycle later. That acknowledge moves the winner's priority into the in-service set. When the core writes end-of-interrupt, the highest in-service priority is retired. A new pending source is presented only if its priority is strictly above the highest priority still in service. A waiting request is therefore pre-empted whenever a higher-priority edge arrives.

The winner's vector and the pending bit cleared on acknowledge come from one arbitration snapshot. This snapshot includes any edge that rises in the acknowledge cycle itself. A late, higher-priority edge is delivered exactly once, and the lower request it displaced stays pending. Acknowledge and end-of-interrupt are plain strobes. The vector return is a one-cycle `ack_vld` pulse that must be taken when it appears; no back-pressure is possible.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all sources have priority 0, `irq_out` is low and `ack_vld` is low. A source with priority 0 never raises `irq_out`.
- R2: An edge-mode source becomes pending on a rising edge of its input, in that same cycle. It stays pending after the input falls, until it is acknowledged.
- R3: A level-mode external source is pending only while its input is high. Nothing is latched, so a pulse that ends before acknowledge leaves no request behind.
- R4: Timer and doorbell sources are edge-sensed even when the configuration write sets the trigger bit (wdata bit 12) to 1.
- R5: Among eligible sources, the one with the highest priority wins. When priorities are equal, the lowest source index wins. Source indices run external lines first, then timers, then doorbells.
- R6: An `ack_rd` cycle yields an `ack_vld` pulse in the next cycle. That pulse carries the vector of the source that won in the `ack_rd` cycle. It also clears that source's edge pending state.
- R7: A higher-priority edge may rise in the same cycle as `ack_rd`. That acknowledge delivers the higher-priority edge, and it is never presented again. The lower-priority source it displaced stays pending and is delivered later.
- R8: A pending source is eligible only if its priority is strictly greater than the highest priority in service. Otherwise `irq_out` stays low for it.
- R9: `eoi_wr` removes the highest in-service priority. Lower pending sources then become eligible in the next cycle.
- R10: `ack_rd` with no eligible source returns the spurious vector `SPUR_VEC` (default 0xFF). It changes neither the in-service state nor any pending state.
- R11: A configuration write to address N_SRC (default 8) is a doorbell. Bit k of the write data makes doorbell k pending. Per-source writes use address = source index, with wdata[7:0] as the vector, [11:8] as the priority and [12] as the trigger (1 = level).
- R12: When `ack_rd` and `eoi_wr` fall in the same cycle, the acknowledge is arbitrated against the in-service level that held before that end-of-interrupt. The end-of-interrupt retires that previous highest level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | N_EXT | External interrupt lines |
| tmr_evt | input | N_TMR | Timer event lines, edge-sensed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | clog2(N_SRC+1) | Source index, or N_SRC for the doorbell |
| cfg_wdata | input | VEC_W+PRIO_W+1 | Write data: vector, priority and trigger, or doorbell bits |
| ack_rd | input | 1 | Acknowledge read strobe from the core |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| irq_out | output | 1 | Request to the core: an eligible source exists |
| ack_vld | output | 1 | Vector return pulse, one cycle after `ack_rd` |
| ack_vec | output | VEC_W | Returned vector, or `SPUR_VEC` |

## Verification
Acknowledge and the rising edge of a higher-priority source can fall in the same cycle. The bench provokes this by raising a priority-5 line in the very cycle it acknowledges a waiting priority-2 line. It then expects the priority-5 vector back and expects that vector never to return after end-of-interrupt. It also expects the priority-2 vector to come out later. Acknowledge and end-of-interrupt also collide in one directed step. There the bench expects the spurious vector, because the pre-retirement level blocks the source, and then expects the retired level to reopen the pending source.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_src_pend.sv
module irq_src_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_mode,
  input  logic evt,
  input  logic lvl,
  input  logic clr,
  output logic pend_q,
  output logic pend_eff
);
  // The effective view folds in an edge arriving this cycle so that an
  // acknowledge in the same cycle can already deliver it.
  always_comb pend_eff = lvl_mode ? lvl : (pend_q | evt);

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (lvl_mode) pend_q <= 1'b0;
    else               pend_q <= (pend_q | evt) & ~clr;
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
)(
  input  logic [N_SRC-1:0]  pend,
  input  logic [PRIO_W-1:0] prio [N_SRC],
  input  logic [PRIO_W-1:0] cur_prio,
  output logic              win_vld,
  output logic [IDX_W-1:0]  win_idx,
  output logic [PRIO_W-1:0] win_prio
);
  // Ascending scan with strict compare: equal priorities keep the lower index.
  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && (prio[i] != '0) && (prio[i] > cur_prio) &&
          (!win_vld || (prio[i] > win_prio))) begin
        win_vld  = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track #(
  parameter int PRIO_W = 4,
  localparam int NLVL = 1 << PRIO_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [NLVL-1:0]   isr_mask,
  output logic [PRIO_W-1:0] cur_prio
);
  logic [NLVL-1:0] mask_nxt;

  always_comb begin
    cur_prio = '0;
    for (int l = 1; l < NLVL; l++)
      if (isr_mask[l]) cur_prio = PRIO_W'(l);
  end

  // Retire uses the level held before this cycle; a pushed level is always above it.
  always_comb begin
    mask_nxt = isr_mask;
    if (pop)  mask_nxt[cur_prio]  = 1'b0;
    if (push) mask_nxt[push_prio] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_mask <= '0;
    else        isr_mask <= mask_nxt;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int N_TMR  = 2,
  parameter int N_IPI  = 2,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = '1,
  localparam int N_SRC  = N_EXT + N_TMR + N_IPI,
  localparam int ADDR_W = $clog2(N_SRC + 1)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_EXT-1:0]        ext_irq,
  input  logic [N_TMR-1:0]        tmr_evt,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [VEC_W+PRIO_W:0]   cfg_wdata,
  input  logic                    ack_rd,
  input  logic                    eoi_wr,
  output logic                    irq_out,
  output logic                    ack_vld,
  output logic [VEC_W-1:0]        ack_vec
);
  localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int NLVL      = 1 << PRIO_W;
  localparam int TMR_BASE  = N_EXT;
  localparam int IPI_BASE  = N_EXT + N_TMR;
  localparam int F_PRIO_LO = VEC_W;
  localparam int F_TRIG    = VEC_W + PRIO_W;

  logic [PRIO_W-1:0] cfg_prio [N_SRC];
  logic [VEC_W-1:0]  cfg_vec  [N_SRC];
  logic [N_SRC-1:0]  lvl_vec;
  logic [N_EXT-1:0]  ext_q;
  logic [N_TMR-1:0]  tmr_q;
  logic [N_SRC-1:0]  src_evt, src_lvl, pend_q, pend_eff, clr_vec;
  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio, cur_prio;
  logic [NLVL-1:0]   isr_mask;
  logic              ack_take, door_wr;

  assign door_wr  = cfg_we && (cfg_addr == ADDR_W'(N_SRC));
  assign ack_take = ack_rd && win_vld;
  assign irq_out  = win_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= '0;
      tmr_q <= '0;
    end else begin
      ext_q <= ext_irq;
      tmr_q <= tmr_evt;
    end
  end

  // Per-source configuration; only external lines may hold level mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_vec <= '0;
      for (int i = 0; i < N_SRC; i++) begin
        cfg_prio[i] <= '0;
        cfg_vec[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (cfg_we && (cfg_addr == ADDR_W'(i))) begin
          cfg_prio[i] <= cfg_wdata[F_TRIG-1:F_PRIO_LO];
          cfg_vec[i]  <= cfg_wdata[VEC_W-1:0];
          lvl_vec[i]  <= (i < N_EXT) ? (cfg_wdata[F_TRIG] == TRIG_LEVEL) : 1'b0;
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i < TMR_BASE) begin : g_ext
        assign src_evt[i] = ext_irq[i] & ~ext_q[i];
        assign src_lvl[i] = ext_irq[i];
      end else if (i < IPI_BASE) begin : g_tmr
        assign src_evt[i] = tmr_evt[i-TMR_BASE] & ~tmr_q[i-TMR_BASE];
        assign src_lvl[i] = 1'b0;
      end else begin : g_ipi
        assign src_evt[i] = door_wr & cfg_wdata[i-IPI_BASE];
        assign src_lvl[i] = 1'b0;
      end

      irq_src_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_mode (lvl_vec[i]),
        .evt      (src_evt[i]),
        .lvl      (src_lvl[i]),
        .clr      (clr_vec[i]),
        .pend_q   (pend_q[i]),
        .pend_eff (pend_eff[i])
      );
    end
  endgenerate

  irq_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend     (pend_eff),
    .prio     (cfg_prio),
    .cur_prio (cur_prio),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  irq_isr_track #(.PRIO_W(PRIO_W)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_take),
    .push_prio (win_prio),
    .pop       (eoi_wr),
    .isr_mask  (isr_mask),
    .cur_prio  (cur_prio)
  );

  // One snapshot of the winner drives both the clear and the returned vector.
  always_comb begin
    clr_vec = '0;
    if (ack_take) clr_vec[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack_vec <= '0;
    end else begin
      ack_vld <= ack_rd;
      if (ack_rd) ack_vec <= win_vld ? cfg_vec[win_idx] : SPUR_VEC;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = '1,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int NLVL  = 1 << PRIO_W
)(
  input logic              clk,
  input logic              rst_n,
  input logic              ack_rd,
  input logic              eoi_wr,
  input logic              irq_out,
  input logic              ack_vld,
  input logic [VEC_W-1:0]  ack_vec,
  input logic              win_vld,
  input logic [IDX_W-1:0]  win_idx,
  input logic [PRIO_W-1:0] win_prio,
  input logic [PRIO_W-1:0] cur_prio,
  input logic [NLVL-1:0]   isr_mask,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  lvl_vec
);
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ack_vld);

  p_no_stray_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rd |=> !ack_vld);

  p_spur_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_out) |=> (ack_vec == SPUR_VEC));

  p_spur_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !win_vld && !eoi_wr) |=> $stable(isr_mask));

  p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && win_vld && !lvl_vec[win_idx]) |=> !pend_q[$past(win_idx)]);

  p_nest_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && win_vld && !eoi_wr) |=>
      ($countones(isr_mask) == $countones($past(isr_mask)) + 1));

  p_eligible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_prio > cur_prio));

  p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !ack_rd && (isr_mask != '0)) |=>
      ($countones(isr_mask) + 1 == $countones($past(isr_mask))));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_rd   (ack_rd),
  .eoi_wr   (eoi_wr),
  .irq_out  (irq_out),
  .ack_vld  (ack_vld),
  .ack_vec  (ack_vec),
  .win_vld  (win_vld),
  .win_idx  (win_idx),
  .win_prio (win_prio),
  .cur_prio (cur_prio),
  .isr_mask (isr_mask),
  .pend_q   (pend_q),
  .lvl_vec  (lvl_vec)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ext_irq;
  logic [1:0]  tmr_evt;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [12:0] cfg_wdata;
  logic        ack_rd, eoi_wr;
  logic        irq_out, ack_vld;
  logic [7:0]  ack_vec;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_evt(tmr_evt),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ack_rd(ack_rd), .eoi_wr(eoi_wr),
    .irq_out(irq_out), .ack_vld(ack_vld), .ack_vec(ack_vec)
  );

  // Row fields: ext[17:14] tmr[13:12] ack[11] eoi[10] exp_irq[9] exp_vld[8] exp_vec[7:0]
  // exp_vld/exp_vec are the result of the acknowledge in the previous row.
  localparam logic [17:0] TBL [38] = '{
    {4'b0001, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10},
    {4'b0001, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10},
    {4'b0001, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0010, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'b0100, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'b0100, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0100, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h12},
    {4'b0100, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'b1000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'b0000, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h14},
    {4'b0001, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h15},
    {4'b0001, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h14},
    {4'b0000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {4'b0000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h10},
    {4'b0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  function automatic string row_tag(int r);
    if (r < 4)       return "R2/R6 edge latch and acknowledge";
    else if (r < 8)  return "R8/R9 eligibility and retire";
    else if (r < 16) return "R7 supersede in acknowledge cycle";
    else if (r < 22) return "R3 level sensing";
    else if (r < 24) return "R5 masked priority";
    else if (r < 28) return "R4 timer forced edge";
    else             return "R5 tie and highest priority";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [3:0] e, logic [1:0] t, logic a, logic o);
    @(negedge clk);
    ext_irq = e; tmr_evt = t; ack_rd = a; eoi_wr = o;
    #1;
  endtask

  task automatic cfg_write(logic [3:0] addr, logic [12:0] data);
    @(negedge clk);
    ext_irq = '0; tmr_evt = '0; ack_rd = 1'b0; eoi_wr = 1'b0;
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_irq = '0; tmr_evt = '0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; ack_rd = 1'b0; eoi_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset irq_out", 16'(irq_out), 16'd0);
    check("R1 reset ack_vld", 16'(ack_vld), 16'd0);
    step(4'b1000, 2'b00, 1'b0, 1'b0);
    check("R1 masked after reset", 16'(irq_out), 16'd0);
    step(4'b0000, 2'b00, 1'b1, 1'b0);
    step(4'b0000, 2'b00, 1'b0, 1'b0);
    check("R10 spurious pulse", 16'(ack_vld), 16'd1);
    check("R10 spurious vector", 16'(ack_vec), 16'hFF);
    check("R10 no request after spurious", 16'(irq_out), 16'd0);

    // Config: {trigger, priority, vector}
    cfg_write(4'd0, {1'b0, 4'd2, 8'h10});
    cfg_write(4'd1, {1'b0, 4'd5, 8'h11});
    cfg_write(4'd2, {1'b1, 4'd3, 8'h12});
    cfg_write(4'd3, {1'b0, 4'd0, 8'h13});
    cfg_write(4'd4, {1'b1, 4'd4, 8'h14});
    cfg_write(4'd5, {1'b0, 4'd2, 8'h15});
    cfg_write(4'd6, {1'b0, 4'd6, 8'h16});
    cfg_write(4'd7, {1'b0, 4'd2, 8'h17});

    for (int r = 0; r < 38; r++) begin
      step(TBL[r][17:14], TBL[r][13:12], TBL[r][11], TBL[r][10]);
      check(row_tag(r), 16'(irq_out), 16'(TBL[r][9]));
      check(row_tag(r), 16'(ack_vld), 16'(TBL[r][8]));
      if (TBL[r][8]) check(row_tag(r), 16'(ack_vec), 16'(TBL[r][7:0]));
    end

    // Doorbell 0 (source 6, priority 6)
    cfg_write(4'd8, 13'd1);
    check("R11 doorbell raises request", 16'(irq_out), 16'd1);
    step(4'b0000, 2'b00, 1'b1, 1'b0);
    step(4'b0000, 2'b00, 1'b0, 1'b0);
    check("R11 doorbell vector", 16'(ack_vec), 16'h16);
    // Lower source blocked while level 6 in service
    step(4'b0001, 2'b00, 1'b0, 1'b0);
    check("R8 lower blocked by service", 16'(irq_out), 16'd0);
    step(4'b0000, 2'b00, 1'b1, 1'b1);
    step(4'b0000, 2'b00, 1'b0, 1'b0);
    check("R12 ack uses pre-retire level", 16'(ack_vec), 16'hFF);
    check("R12 retire reopens pending", 16'(irq_out), 16'd1);
    step(4'b0000, 2'b00, 1'b1, 1'b0);
    step(4'b0000, 2'b00, 1'b0, 1'b1);
    check("R12 pending source delivered", 16'(ack_vec), 16'h10);
    step(4'b0000, 2'b00, 1'b0, 1'b0);
    check("R12 idle after retire", 16'(irq_out), 16'd0);

    // Doorbell 1 (source 7)
    cfg_write(4'd8, 13'd2);
    check("R11 second doorbell raises", 16'(irq_out), 16'd1);
    step(4'b0000, 2'b00, 1'b1, 1'b0);
    step(4'b0000, 2'b00, 1'b0, 1'b1);
    check("R11 second doorbell vector", 16'(ack_vec), 16'h17);
    step(4'b0000, 2'b00, 1'b0, 1'b0);
    check("R11 doorbell delivered once", 16'(irq_out), 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule